// File: doc/BRIEF.md
# Dual-Mode Double-Buffered DAC Input Register

This block is the digital front end of a 16-bit digital-to-analog converter. A code word reaches a first-rank holding register either one bit at a time, on the rising edges of a strobe pin, or as two bytes over an 8-bit bus with separate upper and lower byte enables. A level-sensitive load pin copies the first rank into a second-rank converter register whose contents drive the converter code port. Because of this double buffering, several converters can be written one after another and then updated together.

In serial mode the first rank acts as a 16-bit shift register. The bit order is selected by a bus pin. The bit that leaves the register appears on a serial output, so converters can be chained and fed from one data line. A clear pin forces the converter register to unipolar zero or bipolar zero, chosen by the lower byte enable pin. The clear does not touch the first rank, so the old word can be loaded again afterwards. Every pin passes through a two-flop synchronizer into one system clock domain.

Top module: `dacfe_top`

## Requirements
- R1: After reset, `dac_code` is 0x0000 and `ser_out` is 0, because both registers are cleared.
- R2: With `byte_sel` low (serial mode) and `bus_in[1]` high (MSB first), each `strobe` rising edge shifts `bus_in[0]` into bit 0 and moves the other bits one place up. Sixteen strobes that send a word with its MSB first leave that word in the first rank.
- R3: With `byte_sel` low and `bus_in[1]` low (LSB first), each `strobe` rising edge shifts `bus_in[0]` into bit 15 and moves the other bits one place down. Sixteen strobes that send a word with its LSB first leave that word in the first rank.
- R4: In serial mode `ser_out` shows first-rank bit 15 when MSB first is selected and bit 0 when LSB first is selected. Further strobes therefore pass the stored word out on `ser_out` in the order it was sent in.
- R5: Only a rising edge of `strobe` shifts. Holding `strobe` high for many cycles gives exactly one shift.
- R6: With `byte_sel` high, `hi_en` writes `bus_in` into first-rank bits 15:8 and `lo_en` writes it into bits 7:0. The two bytes may be written in either order.
- R7: In serial mode `hi_en` and `lo_en` leave the first rank unchanged.
- R8: While `load` is high, `dac_code` follows the first rank. While `load` is low and `clear` is low, `dac_code` holds its value even when the first rank changes.
- R9: While `clear` is high, `dac_code` is 0x0000 if `lo_en` is low and 0x8000 if `lo_en` is high. This holds even when `load` is also high.
- R10: A clear leaves the first rank intact. Raising `load` after the clear restores the earlier word on `dac_code`.
- R11: A change on any input pin reaches the registers on the third rising clock edge after it: two synchronizer edges, then one register edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| byte_sel | input | 1 | Mode select: high is byte mode, low is serial mode |
| strobe | input | 1 | Serial shift strobe, acts on its rising edge |
| hi_en | input | 1 | Upper byte enable (byte mode) |
| lo_en | input | 1 | Lower byte enable (byte mode); clear target in both modes |
| load | input | 1 | Level-sensitive transfer from the first rank to the converter register |
| clear | input | 1 | Forces the converter register to zero |
| bus_in | input | 8 | Byte data; in serial mode bit 0 is serial data and bit 1 is the order select |
| ser_out | output | 1 | Bit at the outgoing end of the shift register |
| dac_code | output | 16 | Converter register contents |

## Verification
Every pin level reaches the registers on the third rising edge after it is driven: two synchronizer flops, then the register update. The serial output is combinational from the first rank, so it moves in that same cycle. The bench drives inputs on falling edges. It holds every strobe, enable and load for at least three edges and samples on a falling edge after that. The clear latency check samples after two edges, where the old code must still show, and again after the third edge, where zero must appear. The first rank is never read directly; it is observed through a load pulse or through the serial output.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int unsigned CODE_W      = 16;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned SYNC_STAGES = 2;

    // Synchronized pin bundle, in the order they are packed at the top.
    typedef struct packed {
        logic              byte_mode;
        logic              strobe;
        logic              hi_en;
        logic              lo_en;
        logic              load;
        logic              clear;
        logic [BYTE_W-1:0] bus;
    } pins_t;

    localparam int unsigned PINS_W = $bits(pins_t);

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int unsigned W      = 14,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/dacfe_rank1.sv
module dacfe_rank1 #(
    parameter int unsigned W = 16,
    parameter int unsigned B = 8,
    localparam int unsigned LANES = W / B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_mode,
    input  logic             shift_en,
    input  logic             msb_first,
    input  logic             ser_in,
    input  logic [LANES-1:0] lane_we,
    input  logic [B-1:0]     bus,
    output logic [W-1:0]     word,
    output logic             ser_out
);

    typedef struct packed {
        logic [W-1:0] word;
    } r1_state_t;

    r1_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (byte_mode) begin
            for (int l = 0; l < int'(LANES); l++) begin
                if (lane_we[l]) begin
                    st_d.word[l*B +: B] = bus;
                end
            end
        end else if (shift_en) begin
            if (msb_first) begin
                st_d.word = {st_q.word[W-2:0], ser_in};
            end else begin
                st_d.word = {ser_in, st_q.word[W-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word    = st_q.word;
    assign ser_out = msb_first ? st_q.word[W-1] : st_q.word[0];

    AST_SHIFT_MSB_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode && shift_en && msb_first) |=> (word[0] == $past(ser_in))); // R2

    AST_SHIFT_MSB_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode && shift_en && msb_first) |=> (word[W-1:1] == $past(word[W-2:0]))); // R2

    AST_SHIFT_LSB_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode && shift_en && !msb_first) |=> (word[W-1] == $past(ser_in))); // R3

    AST_SERIAL_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode && !shift_en) |=> $stable(word)); // R7

    AST_BYTE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && (lane_we == '0)) |=> $stable(word)); // R6

endmodule

// File: rtl/dacfe_rank2.sv
module dacfe_rank2 #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clear,
    input  logic         bipolar,
    input  logic [W-1:0] word,
    output logic [W-1:0] code
);

    localparam logic [W-1:0] UNI_ZERO = '0;
    localparam logic [W-1:0] BIP_ZERO = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] code;
    } r2_state_t;

    r2_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.code = bipolar ? BIP_ZERO : UNI_ZERO;
        end else if (load) begin
            st_d.code = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

    AST_CLEAR_UNIPOLAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !bipolar) |=> (code == '0)); // R9

    AST_CLEAR_BIPOLAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && bipolar) |=> (code[W-1] && (code[W-2:0] == '0))); // R9

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (code == $past(word))); // R8

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clear) |=> $stable(code)); // R8

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int unsigned CW  = CODE_W,
    parameter int unsigned BW  = BYTE_W,
    parameter int unsigned SYN = SYNC_STAGES,
    localparam int unsigned LANES = CW / BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_sel,
    input  logic          strobe,
    input  logic          hi_en,
    input  logic          lo_en,
    input  logic          load,
    input  logic          clear,
    input  logic [BW-1:0] bus_in,
    output logic          ser_out,
    output logic [CW-1:0] dac_code
);

    localparam int unsigned PW = 6 + BW;

    logic [PW-1:0] raw_pins;
    logic [PW-1:0] sync_pins;

    logic          s_byte_mode, s_strobe, s_hi, s_lo, s_load, s_clear;
    logic [BW-1:0] s_bus;

    typedef struct packed {
        logic strobe_prev;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             shift_en;
    logic [LANES-1:0] lane_we;
    logic [CW-1:0]    first_word;

    assign raw_pins = {byte_sel, strobe, hi_en, lo_en, load, clear, bus_in};

    dacfe_sync #(.W(PW), .STAGES(SYN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_pins),
        .sync_out (sync_pins)
    );

    assign {s_byte_mode, s_strobe, s_hi, s_lo, s_load, s_clear, s_bus} = sync_pins;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = s_strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_en = s_strobe && !st_q.strobe_prev;

    // Lane 0 is the lower byte; the top lane takes the upper enable.
    generate
        if (LANES == 2) begin : g_two_lanes
            assign lane_we = {s_hi, s_lo};
        end else begin : g_wide_lanes
            always_comb begin
                lane_we          = '0;
                lane_we[0]       = s_lo;
                lane_we[LANES-1] = s_hi;
            end
        end
    endgenerate

    dacfe_rank1 #(.W(CW), .B(BW)) u_rank1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (s_byte_mode),
        .shift_en  (shift_en),
        .msb_first (s_bus[1]),
        .ser_in    (s_bus[0]),
        .lane_we   (lane_we),
        .bus       (s_bus),
        .word      (first_word),
        .ser_out   (ser_out)
    );

    dacfe_rank2 #(.W(CW)) u_rank2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (s_load),
        .clear   (s_clear),
        .bipolar (s_lo),
        .word    (first_word),
        .code    (dac_code)
    );

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !shift_en); // R5

endmodule

// File: tb/sim_dacfe_top.sv
`timescale 1ns/1ps
module sim_dacfe_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_sel = 1'b0;
    logic        strobe = 1'b0;
    logic        hi_en = 1'b0;
    logic        lo_en = 1'b0;
    logic        load = 1'b0;
    logic        clear = 1'b0;
    logic [7:0]  bus_in = '0;
    logic        ser_out;
    logic [15:0] dac_code;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dacfe_top u0 (
        .clk(clk), .rst_n(rst_n), .byte_sel(byte_sel), .strobe(strobe),
        .hi_en(hi_en), .lo_en(lo_en), .load(load), .clear(clear),
        .bus_in(bus_in), .ser_out(ser_out), .dac_code(dac_code)
    );

    // {hi_first, hi_byte, lo_byte, expected code}
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 8'hA5, 8'h3C, 16'hA53C},
        {1'b0, 8'h12, 8'hF0, 16'h12F0},
        {1'b1, 8'hFF, 8'hFF, 16'hFFFF},
        {1'b0, 8'h00, 8'h01, 16'h0001},
        {1'b1, 8'h80, 8'h00, 16'h8000},
        {1'b0, 8'h7F, 8'hFE, 16'h7FFE}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic upper, input logic [7:0] b);
        bus_in = b;
        if (upper) hi_en = 1'b1; else lo_en = 1'b1;
        wait_cyc(4);
        hi_en = 1'b0;
        lo_en = 1'b0;
        wait_cyc(3);
    endtask

    task automatic pulse_load();
        load = 1'b1;
        wait_cyc(4);
        load = 1'b0;
        wait_cyc(3);
    endtask

    task automatic pulse_strobe(input logic bit_val);
        bus_in[0] = bit_val;
        strobe = 1'b1;
        wait_cyc(3);
        strobe = 1'b0;
        wait_cyc(3);
    endtask

    task automatic send_serial(input logic [15:0] w, input logic msb);
        bus_in[1] = msb;
        for (int i = 0; i < 16; i++) begin
            pulse_strobe(msb ? w[15-i] : w[i]);
        end
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 reset code", dac_code, 16'h0000);
        chk("R1 reset ser_out", {15'd0, ser_out}, 16'h0000);

        // R6 / R8: byte mode vectors, both write orders
        byte_sel = 1'b1;
        wait_cyc(4);
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][32]) begin
                write_byte(1'b1, VEC[v][31:24]);
                write_byte(1'b0, VEC[v][23:16]);
            end else begin
                write_byte(1'b0, VEC[v][23:16]);
                write_byte(1'b1, VEC[v][31:24]);
            end
            pulse_load();
            chk("R6 byte load", dac_code, VEC[v][15:0]);
        end

        // R8: first rank changes without load, code holds
        write_byte(1'b1, 8'h11);
        write_byte(1'b0, 8'h22);
        chk("R8 hold without load", dac_code, 16'h7FFE);
        pulse_load();
        chk("R8 load copies", dac_code, 16'h1122);

        // Serial mode
        byte_sel = 1'b0;
        bus_in = '0;
        wait_cyc(4);
        send_serial(16'hC3A5, 1'b1);
        chk("R4 ser_out msb end", {15'd0, ser_out}, 16'h0001);
        pulse_load();
        chk("R2 serial msb first", dac_code, 16'hC3A5);

        send_serial(16'h1E69, 1'b0);
        chk("R4 ser_out lsb end", {15'd0, ser_out}, 16'h0001);
        pulse_load();
        chk("R3 serial lsb first", dac_code, 16'h1E69);

        // R5: long high strobe gives one shift (MSB first)
        send_serial(16'h4321, 1'b1);
        bus_in[0] = 1'b1;
        strobe = 1'b1;
        wait_cyc(20);
        strobe = 1'b0;
        wait_cyc(3);
        pulse_load();
        chk("R5 single shift on held strobe", dac_code, 16'h8643);

        // R7: byte enables ignored in serial mode
        hi_en = 1'b1;
        lo_en = 1'b1;
        wait_cyc(5);
        hi_en = 1'b0;
        lo_en = 1'b0;
        wait_cyc(3);
        pulse_load();
        chk("R7 enables ignored in serial", dac_code, 16'h8643);

        // R4: daisy chain, old word comes out MSB first
        send_serial(16'hB2D4, 1'b1);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a_word;
            logic [15:0] b_word;
            a_word = 16'hB2D4;
            b_word = 16'h5A0F;
            chk("R4 chained bit", {15'd0, ser_out}, {15'd0, a_word[15-i]});
            pulse_strobe(b_word[15-i]);
        end
        pulse_load();
        chk("R2 chained new word", dac_code, 16'h5A0F);

        // R11 / R9: clear latency to unipolar zero
        lo_en = 1'b0;
        wait_cyc(4);
        clear = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 clear not yet seen", dac_code, 16'h5A0F);
        wait_cyc(1);
        chk("R11 clear on third edge", dac_code, 16'h0000);
        load = 1'b1;
        wait_cyc(5);
        chk("R9 clear beats load", dac_code, 16'h0000);
        clear = 1'b0;
        wait_cyc(4);
        chk("R10 first rank kept", dac_code, 16'h5A0F);
        load = 1'b0;
        wait_cyc(3);

        // R9: bipolar zero
        lo_en = 1'b1;
        wait_cyc(4);
        clear = 1'b1;
        wait_cyc(4);
        chk("R9 bipolar zero", dac_code, 16'h8000);
        clear = 1'b0;
        lo_en = 1'b0;
        wait_cyc(4);
        chk("R8 hold after clear", dac_code, 16'h8000);
        pulse_load();
        chk("R10 reload after bipolar clear", dac_code, 16'h5A0F);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule